// File: doc/BRIEF.md
# Three-Mode Configurable Logic Cell

The cell computes one output bit from nine leaf input bits. The output comes from one of three structures. The first is a single 4-input look-up table. The second is two 4-input tables in a chain, where the second table can take the first table's output on any of its inputs. The third is two 4-input tables whose outputs feed a fixed 2:1 multiplexer. A leading type byte in a configuration record of up to twelve bytes picks the structure. The rest of the record holds the truth tables and the 4-bit input selectors. Each selector routes constant 0, constant 1, a leaf, or the chained table output to one table input.

The record is written one byte per cycle into a staging store. A commit strobe copies the staged record, together with any byte written in the same cycle, into the active record that drives the output. A partly written record therefore never reaches the output. When a committed record holds an unknown type or a selector out of range, the output is held at 0 and a sticky error flag is raised. Only reset clears that flag. Leaf inputs reach the output through combinational logic only.

Top module: `cfg_logic_cell`

## Requirements
- R1: After reset, out_o is 0 for any leaf value and cfg_err_o is 0.
- R2: Type byte 0 (byte index 0) selects a single table. Bytes 1 (low) and 2 (high) hold truth table T, and out_o = T[{leaf3,leaf2,leaf1,leaf0}]. Leaves 4 to 8 have no effect.
- R3: A selector nibble is decoded as follows: 0 gives constant 0, 1 gives constant 1, and 2+k gives leaf k. Selector n sits in byte 1+n/2, in the low nibble for even n and the high nibble for odd n.
- R4: Type byte 1 selects the chain. Selectors 0 to 3 drive table A and selectors 4 to 7 drive table B. The truth tables sit in bytes 5-6 (A) and 7-8 (B), low byte first. On table B, selector value 9 routes table A's output. The cell output is table B's output. A table input of index i is bit i of that table's index.
- R5: Type byte 2 selects the mux form. Selectors 0 to 3 drive table A, 4 to 7 drive table B, and 8 drives the select. The truth tables sit in bytes 6-7 (A) and 8-9 (B). The output is B when the select is 1 and A when it is 0.
- R6: A committed record has an invalid selector in these cases: in the chain, a table A selector above 8 or a table B selector above 9; in the mux form, any selector above 10. Such a record forces out_o to 0 and sets cfg_err_o on the edge of the commit.
- R7: A committed record with a type byte above 2 forces out_o to 0 and sets cfg_err_o.
- R8: cfg_err_o stays 1 until reset. A later valid commit drives out_o again, while cfg_err_o stays 1.
- R9: Byte writes without a commit strobe leave out_o unchanged. A commit takes effect on the clock edge that samples the strobe.
- R10: A byte written in the same cycle as the commit strobe is part of the committed record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| leaf_i | input | 9 | Leaf input bits |
| cfg_we_i | input | 1 | Configuration byte write enable |
| cfg_idx_i | input | 4 | Byte index into the record (indexes of 12 and above are ignored) |
| cfg_byte_i | input | 8 | Configuration byte value |
| cfg_done_i | input | 1 | Commit strobe for the staged record |
| out_o | output | 1 | Cell output |
| cfg_err_o | output | 1 | Sticky invalid-configuration flag |

## Verification
A leaf change reaches out_o in the same cycle. The bench therefore drives leaves on the falling edge and samples out_o one nanosecond later. A commit, including a byte written alongside the strobe, changes out_o and cfg_err_o on the rising edge that samples cfg_done_i. Each load ends with the strobe held for one full cycle, and the bench reads the results only after the next falling edge. The checks that byte writes alone leave the output unchanged sample between the writes and the strobe, while the staged record already differs from the active one.

// File: rtl/cfg_cell_pkg.sv
`timescale 1ns/1ps
package cfg_cell_pkg;
  parameter int unsigned N_LEAF    = 9;
  parameter int unsigned REC_BYTES = 12;
  parameter int unsigned LUT_K     = 4;
  parameter int unsigned CASC_LEAF = 7;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned IDX_W   = $clog2(REC_BYTES);
  localparam int unsigned REC_W   = REC_BYTES * 8;
  localparam int unsigned TT_W    = 1 << LUT_K;
  localparam int unsigned TT_B    = TT_W / 8;
  localparam int unsigned N_SEL   = 2 * LUT_K + 1;
  // byte offsets of truth tables, derived from selector packing
  localparam int unsigned TT_A_SINGLE = 1;
  localparam int unsigned TT_A_CASC   = 1 + (2 * LUT_K * SEL_W) / 8;
  localparam int unsigned TT_B_CASC   = TT_A_CASC + TT_B;
  localparam int unsigned TT_A_MUX    = 1 + (N_SEL * SEL_W + 7) / 8;
  localparam int unsigned TT_B_MUX    = TT_A_MUX + TT_B;

  localparam logic [7:0] CT_SINGLE  = 8'd0;
  localparam logic [7:0] CT_CASCADE = 8'd1;
  localparam logic [7:0] CT_MUX     = 8'd2;

  localparam logic [SEL_W-1:0] SEL_ZERO  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ONE   = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_LEAF0 = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_FB    = SEL_W'(2 + CASC_LEAF);
  localparam logic [SEL_W-1:0] SEL_CMAX  = SEL_W'(2 + CASC_LEAF - 1);
  localparam logic [SEL_W-1:0] SEL_LMAX  = SEL_W'(2 + N_LEAF - 1);

  function automatic logic [SEL_W-1:0] sel_at(input logic [REC_W-1:0] rec, input int n);
    return rec[8 + SEL_W*n +: SEL_W];
  endfunction

  function automatic logic [TT_W-1:0] tt_at(input logic [REC_W-1:0] rec, input int b);
    return rec[8*b +: TT_W];
  endfunction

  function automatic logic rec_ok(input logic [REC_W-1:0] rec);
    logic ok;
    logic [SEL_W-1:0] s;
    ok = 1'b1;
    case (rec[7:0])
      CT_SINGLE: ok = 1'b1;
      CT_CASCADE: begin
        for (int n = 0; n < 2*LUT_K; n++) begin
          s = sel_at(rec, n);
          if (n < LUT_K) begin
            if (s > SEL_CMAX) ok = 1'b0;
          end else if (s > SEL_FB) ok = 1'b0;
        end
      end
      CT_MUX: begin
        for (int n = 0; n < N_SEL; n++) begin
          s = sel_at(rec, n);
          if (s > SEL_LMAX) ok = 1'b0;
        end
      end
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/cfg_cell_store.sv
`timescale 1ns/1ps
module cfg_cell_store
  import cfg_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic             done_i,
  output logic [REC_W-1:0] act_o,
  output logic             act_ok_o,
  output logic             err_o
);
  logic [REC_BYTES-1:0][7:0] stage_q, stage_d, act_q;
  logic act_ok_q, err_q, next_ok;

  for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
    assign stage_d[b] = (we_i && idx_i == IDX_W'(b)) ? byte_i : stage_q[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[b] <= '0;
      else         stage_q[b] <= stage_d[b];
    end
  end

  assign next_ok = rec_ok(stage_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      act_ok_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (done_i) begin
      act_q    <= stage_d;
      act_ok_q <= next_ok;
      err_q    <= err_q | ~next_ok;
    end
  end

  assign act_o    = act_q;
  assign act_ok_o = act_ok_q;
  assign err_o    = err_q;
endmodule

// File: rtl/cfg_cell_sel.sv
`timescale 1ns/1ps
module cfg_cell_sel
  import cfg_cell_pkg::*;
(
  input  logic [SEL_W-1:0]  code_i,
  input  logic [N_LEAF-1:0] leaf_i,
  input  logic              fb_i,
  input  logic              fb_en_i,
  output logic              bit_o
);
  logic [SEL_W-1:0] li;
  assign li = code_i - SEL_LEAF0;

  always_comb begin
    bit_o = 1'b0;
    if (code_i == SEL_ONE)                                bit_o = 1'b1;
    else if (code_i == SEL_ZERO)                          bit_o = 1'b0;
    else if (fb_en_i && code_i == SEL_FB)                 bit_o = fb_i;
    else if (code_i >= SEL_LEAF0 && code_i <= SEL_LMAX)   bit_o = leaf_i[li];
  end
endmodule

// File: rtl/cfg_cell_lut.sv
`timescale 1ns/1ps
module cfg_cell_lut
  import cfg_cell_pkg::*;
(
  input  logic [TT_W-1:0]  tt_i,
  input  logic [LUT_K-1:0] in_i,
  output logic             out_o
);
  assign out_o = tt_i[in_i];
endmodule

// File: rtl/cfg_logic_cell.sv
`timescale 1ns/1ps
module cfg_logic_cell
  import cfg_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LEAF-1:0] leaf_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [7:0]        cfg_byte_i,
  input  logic              cfg_done_i,
  output logic              out_o,
  output logic              cfg_err_o
);
  logic [REC_W-1:0] rec;
  logic             rec_ok_q;
  logic [7:0]       ct;
  logic [LUT_K-1:0] a_sel, a_in, b_in;
  logic [TT_W-1:0]  tt_a, tt_b;
  logic             a_out, b_out, m_sel, res;

  cfg_cell_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .byte_i  (cfg_byte_i),
    .done_i  (cfg_done_i),
    .act_o   (rec),
    .act_ok_o(rec_ok_q),
    .err_o   (cfg_err_o)
  );

  assign ct = rec[7:0];

  for (genvar i = 0; i < LUT_K; i++) begin : g_in
    cfg_cell_sel u_sel_a (
      .code_i (sel_at(rec, i)),
      .leaf_i (leaf_i),
      .fb_i   (1'b0),
      .fb_en_i(1'b0),
      .bit_o  (a_sel[i])
    );
    // single-table form wires leaves straight to the inputs
    assign a_in[i] = (ct == CT_SINGLE) ? leaf_i[i] : a_sel[i];
    cfg_cell_sel u_sel_b (
      .code_i (sel_at(rec, LUT_K + i)),
      .leaf_i (leaf_i),
      .fb_i   (a_out),
      .fb_en_i(ct == CT_CASCADE),
      .bit_o  (b_in[i])
    );
  end

  cfg_cell_sel u_sel_m (
    .code_i (sel_at(rec, 2*LUT_K)),
    .leaf_i (leaf_i),
    .fb_i   (1'b0),
    .fb_en_i(1'b0),
    .bit_o  (m_sel)
  );

  always_comb begin
    case (ct)
      CT_CASCADE: begin tt_a = tt_at(rec, TT_A_CASC); tt_b = tt_at(rec, TT_B_CASC); end
      CT_MUX:     begin tt_a = tt_at(rec, TT_A_MUX);  tt_b = tt_at(rec, TT_B_MUX);  end
      default:    begin tt_a = tt_at(rec, TT_A_SINGLE); tt_b = '0; end
    endcase
  end

  cfg_cell_lut u_lut_a (.tt_i(tt_a), .in_i(a_in), .out_o(a_out));
  cfg_cell_lut u_lut_b (.tt_i(tt_b), .in_i(b_in), .out_o(b_out));

  always_comb begin
    case (ct)
      CT_SINGLE:  res = a_out;
      CT_CASCADE: res = b_out;
      CT_MUX:     res = m_sel ? b_out : a_out;
      default:    res = 1'b0;
    endcase
  end

  assign out_o = rec_ok_q & res;
endmodule

// File: rtl/cfg_logic_cell_chk.sv
`timescale 1ns/1ps
module cfg_logic_cell_chk
  import cfg_cell_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_LEAF-1:0] leaf_i,
  input logic              cfg_we_i,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic [7:0]        cfg_byte_i,
  input logic              cfg_done_i,
  input logic              out_o,
  input logic              cfg_err_o
);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  p_err_on_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_done_i && !cfg_err_o) |=> !cfg_err_o);

  p_hold_no_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_i |=> ($stable(leaf_i) -> $stable(out_o)));

  p_bad_type_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && cfg_we_i && cfg_idx_i == '0 && cfg_byte_i > 8'd2) |=> (cfg_err_o && !out_o));
endmodule

bind cfg_logic_cell cfg_logic_cell_chk u_chk (.*);

// File: tb/cfg_logic_cell_test.sv
`timescale 1ns/1ps
module cfg_logic_cell_test;
  import cfg_cell_pkg::*;

  typedef struct packed {
    logic [95:0] rec;
    logic [8:0]  leaf;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [95:0] V_AND4  = 96'h000000000000000000800000; // type 0, T=8000
  localparam logic [95:0] V_XOR4  = 96'h000000000000000000699600; // type 0, T=6996
  localparam logic [95:0] V_CASC  = 96'h000000666688880189003201; // (l0&l1)^l6
  localparam logic [95:0] V_MUX   = 96'h0000AAAAAAAA06000A000202; // l4 ? l8 : l0
  localparam logic [95:0] V_CONST = 96'h000000AAAA80000009111101; // always 1
  localparam logic [95:0] E_CA9   = 96'h000000666688880189003901; // A sel 9
  localparam logic [95:0] E_CB10  = 96'h00000066668888018A003201; // B sel 10
  localparam logic [95:0] E_MX11  = 96'h0000AAAAAAAA0B000A000202; // mux sel 11
  localparam logic [95:0] E_TYPE3 = 96'h000000000000000000800003; // type 3

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{V_AND4,  9'h00F, 1'b1, 4'd2},   // R2
    '{V_AND4,  9'h007, 1'b0, 4'd2},
    '{V_XOR4,  9'h1F0, 1'b0, 4'd2},   // R2 upper leaves ignored
    '{V_XOR4,  9'h001, 1'b1, 4'd2},
    '{V_XOR4,  9'h00E, 1'b1, 4'd2},
    '{V_CASC,  9'h003, 1'b1, 4'd4},   // R4
    '{V_CASC,  9'h043, 1'b0, 4'd4},
    '{V_CASC,  9'h040, 1'b1, 4'd4},
    '{V_CASC,  9'h001, 1'b0, 4'd4},
    '{V_MUX,   9'h001, 1'b1, 4'd5},   // R5
    '{V_MUX,   9'h100, 1'b0, 4'd5},
    '{V_MUX,   9'h110, 1'b1, 4'd5},
    '{V_MUX,   9'h011, 1'b0, 4'd5},
    '{V_CONST, 9'h000, 1'b1, 4'd3},   // R3 constants
    '{V_CONST, 9'h1FF, 1'b1, 4'd3}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] leaf_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [3:0] cfg_idx_i = '0;
  logic [7:0] cfg_byte_i = '0;
  logic       cfg_done_i = 1'b0;
  logic       out_o, cfg_err_o;
  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  cfg_logic_cell uut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] b, input logic done);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(idx); cfg_byte_i = b; cfg_done_i = done;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_done_i = 1'b0;
  endtask

  task automatic stage(input logic [95:0] rec);
    for (int b = 0; b < 12; b++) wr(b, rec[8*b +: 8], 1'b0);
  endtask

  task automatic commit();
    @(negedge clk_i);
    cfg_done_i = 1'b1;
    @(negedge clk_i);
    cfg_done_i = 1'b0;
  endtask

  task automatic load(input logic [95:0] rec);
    stage(rec);
    commit();
  endtask

  task automatic probe(input logic [8:0] l, output logic o);
    @(negedge clk_i);
    leaf_i = l;
    #1 o = out_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++; n_run++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic o;
    logic [95:0] cur;
    leaf_i = 9'h1FF;
    repeat (2) @(negedge clk_i);
    #1;
    chk("R1 reset out", out_o, 1'b0);
    chk("R1 reset err", cfg_err_o, 1'b0);
    rst_ni = 1'b1;

    cur = '1;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rec != cur) begin
        load(VECS[i].rec);
        cur = VECS[i].rec;
      end
      probe(VECS[i].leaf, o);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), o, VECS[i].exp);
    end
    chk("R3 no error on valid records", cfg_err_o, 1'b0);

    // R9: staged bytes do not reach the output before commit
    load(V_AND4);
    stage(V_XOR4);
    probe(9'h00F, o); chk("R9 staged only", o, 1'b1);
    commit();
    probe(9'h00F, o); chk("R9 after commit", o, 1'b0);

    // R10: byte written with the strobe is included
    load(V_AND4);
    wr(0, 8'h00, 1'b0);
    wr(1, 8'h96, 1'b0);
    wr(2, 8'h69, 1'b1);
    probe(9'h00F, o); chk("R10 merged byte", o, 1'b0);
    probe(9'h001, o); chk("R10 merged byte", o, 1'b1);

    // R6: table A selector 9 in chain
    do_reset();
    load(E_CA9);
    probe(9'h003, o);
    chk("R6 chain A sel out", o, 1'b0);
    chk("R6 chain A sel err", cfg_err_o, 1'b1);
    // R8: sticky, but a valid record drives again
    load(V_AND4);
    probe(9'h00F, o);
    chk("R8 valid after bad out", o, 1'b1);
    chk("R8 err sticky", cfg_err_o, 1'b1);

    do_reset();
    #1 chk("R1 err cleared by reset", cfg_err_o, 1'b0);
    load(E_MX11);
    probe(9'h001, o);
    chk("R6 mux sel 11 out", o, 1'b0);
    chk("R6 mux sel 11 err", cfg_err_o, 1'b1);

    do_reset();
    load(E_CB10);
    probe(9'h003, o);
    chk("R6 chain B sel 10 out", o, 1'b0);
    chk("R6 chain B sel 10 err", cfg_err_o, 1'b1);

    do_reset();
    load(E_TYPE3);
    probe(9'h00F, o);
    chk("R7 unknown type out", o, 1'b0);
    chk("R7 unknown type err", cfg_err_o, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule